// File: doc/BRIEF.md
# UART Interrupt Identification and Enable

This block collects five level-sensitive interrupt requests of a UART: receiver line status, received data available, character timeout, transmitter holding register empty and modem status. Each request is gated by a bit of a four-bit interrupt enable register. The enabled requests drive a registered interrupt line. An identification byte names the most urgent enabled request and carries the FIFO-mode marker bits.

Software writes the enable byte through a one-cycle write strobe and reads it back at any time. A read of the identification byte is signalled by a level strobe that stays high for the whole access. While that strobe is high the identification byte is frozen. Requests that change during the access keep feeding the interrupt line. Once the strobe drops, the byte takes up the current most urgent request on the next edge.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the interrupt line is low and the identification byte reads 0x01.
- R2: A write stores data bits 3:0 into the enable register; enable bits 7:4 always read 0, so writing 0xFF reads back 0x0F.
- R3: A request whose enable bit is 0 neither appears in the identification byte nor raises the interrupt line.
- R4: Identification bit 0 is 0 while an enabled request is pending and 1 when none is. The interrupt line is high, one edge after the cause, exactly when an enabled request is pending.
- R5: Priority, highest first, with identification bits 3:1: line status 011, received data 010, timeout 110, holding register empty 001, modem status 000. With no request pending, bits 3:1 are 000.
- R6: Identification bits 7:6 read 11 in FIFO mode and 00 otherwise. Bits 5:4 always read 0.
- R7: Outside FIFO mode the timeout request is ignored: identification bit 3 stays 0 and the request does not raise the interrupt line.
- R8: While the read strobe is high, the identification byte holds its value. On the first edge after the strobe falls, it shows the current highest request.
- R9: The interrupt line keeps following the enabled pending requests while the identification byte is frozen.
- R10: Enable bit 0 gates received data and timeout, bit 1 holding register empty, bit 2 line status and bit 3 modem status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | FIFO mode enabled |
| rls_i | input | 1 | Receiver line status request |
| rda_i | input | 1 | Received data available request |
| cto_i | input | 1 | Character timeout request |
| thre_i | input | 1 | Transmit holding register empty request |
| msi_i | input | 1 | Modem status request |
| iir_rd_i | input | 1 | Identification read in progress (level) |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| ier_o | output | 8 | Enable register read value |
| iir_o | output | 8 | Identification byte |
| intr_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach is a frozen read that overlaps a change in the pending set. The bench holds the read strobe high across several edges. During the read it first raises a request of higher priority, then drops every request. It checks that the identification byte keeps its old code while the interrupt line falls. It then lowers the strobe with a new request pending and checks that the byte takes that code on the very next edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int IER_W   = 4;
  localparam int DATA_W  = 8;

  // source index: 0 is the highest priority
  localparam int SRC_RLS  = 0;
  localparam int SRC_RDA  = 1;
  localparam int SRC_CTO  = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MSI  = 4;

  typedef enum logic [2:0] {
    ID_MSI  = 3'b000,
    ID_THRE = 3'b001,
    ID_RDA  = 3'b010,
    ID_RLS  = 3'b011,
    ID_CTO  = 3'b110
  } irq_id_e;

  function automatic irq_id_e id_of(int idx);
    case (idx)
      SRC_RLS:  return ID_RLS;
      SRC_RDA:  return ID_RDA;
      SRC_CTO:  return ID_CTO;
      SRC_THRE: return ID_THRE;
      default:  return ID_MSI;
    endcase
  endfunction

  // enable bit gating each source
  function automatic int en_bit(int idx);
    case (idx)
      SRC_RLS:  return 2;
      SRC_RDA:  return 0;
      SRC_CTO:  return 0;
      SRC_THRE: return 1;
      default:  return 3;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_ier.sv
module uart_irq_ier
  import uart_irq_pkg::*;
#(
  parameter int W  = IER_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [W-1:0]  en_o,
  output logic [DW-1:0] rdata_o
);
  localparam int PAD = DW - W;

  logic [W-1:0] en_q;
  logic         unused_hi;

  assign unused_hi = ^wdata_i[DW-1:W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i[W-1:0];
  end

  assign en_o    = en_q;
  assign rdata_o = {{PAD{1'b0}}, en_q};
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = IER_W
) (
  input  logic [N-1:0] src_i,
  input  logic [W-1:0] en_i,
  input  logic         fifo_i,
  output logic [N-1:0] act_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    localparam int EB = en_bit(g);
    if (g == SRC_CTO) begin : g_cto
      // timeout exists only with FIFOs on
      assign act_o[g] = src_i[g] & en_i[EB] & fifo_i;
    end else begin : g_std
      assign act_o[g] = src_i[g] & en_i[EB];
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0] act_i,
  output logic         pend_o,
  output irq_id_e      id_o
);
  always_comb begin
    id_o = ID_MSI;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) id_o = id_of(i);
    end
  end

  assign pend_o = |act_i;
endmodule

// File: rtl/uart_irq_iir.sv
module uart_irq_iir
  import uart_irq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          pend_i,
  input  irq_id_e       id_i,
  input  logic          fifo_i,
  output logic [DW-1:0] iir_o
);
  localparam int PAD = DW - 6;

  logic [DW-1:0] iir_d, iir_q;

  always_comb begin
    iir_d        = '0;
    iir_d[0]     = ~pend_i;
    iir_d[3:1]   = pend_i ? id_i : ID_MSI;
    iir_d[DW-1:DW-2] = {2{fifo_i}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      iir_q <= {{(DW-1){1'b0}}, 1'b1};
    else if (!hold_i) iir_q <= iir_d;
  end

  assign iir_o = iir_q;

  logic [PAD-1:0] unused_pad;
  assign unused_pad = '0;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_mode_i,
  input  logic              rls_i,
  input  logic              rda_i,
  input  logic              cto_i,
  input  logic              thre_i,
  input  logic              msi_i,
  input  logic              iir_rd_i,
  input  logic              ier_wr_i,
  input  logic [DATA_W-1:0] ier_wdata_i,
  output logic [DATA_W-1:0] ier_o,
  output logic [DATA_W-1:0] iir_o,
  output logic              intr_o
);
  logic [NUM_SRC-1:0] src, act;
  logic [IER_W-1:0]   en;
  logic               pend;
  irq_id_e            id;
  logic               intr_q;

  always_comb begin
    src           = '0;
    src[SRC_RLS]  = rls_i;
    src[SRC_RDA]  = rda_i;
    src[SRC_CTO]  = cto_i;
    src[SRC_THRE] = thre_i;
    src[SRC_MSI]  = msi_i;
  end

  uart_irq_ier #(.W(IER_W), .DW(DATA_W)) u_ier (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ier_wr_i),
    .wdata_i (ier_wdata_i),
    .en_o    (en),
    .rdata_o (ier_o)
  );

  uart_irq_mask #(.N(NUM_SRC), .W(IER_W)) u_mask (
    .src_i  (src),
    .en_i   (en),
    .fifo_i (fifo_mode_i),
    .act_o  (act)
  );

  uart_irq_prio #(.N(NUM_SRC)) u_prio (
    .act_i  (act),
    .pend_o (pend),
    .id_o   (id)
  );

  uart_irq_iir #(.DW(DATA_W)) u_iir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (iir_rd_i),
    .pend_i (pend),
    .id_i   (id),
    .fifo_i (fifo_mode_i),
    .iir_o  (iir_o)
  );

  // line is not frozen by a read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) intr_q <= 1'b0;
    else         intr_q <= pend;
  end

  assign intr_o = intr_q;
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fifo_mode_i,
  input logic       rls_i,
  input logic       rda_i,
  input logic       cto_i,
  input logic       thre_i,
  input logic       msi_i,
  input logic       iir_rd_i,
  input logic       ier_wr_i,
  input logic [7:0] ier_wdata_i,
  input logic [7:0] ier_o,
  input logic [7:0] iir_o,
  input logic       intr_o
);
  // R2
  ier_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_o[7:4] == 4'h0);

  // R2
  ier_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_wr_i |=> $stable(ier_o));

  // R3
  all_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o[3:0] == 4'h0) |=> !intr_o);

  // R6
  mid_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[5:4] == 2'b00);

  // R7
  no_fifo_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_mode_i && !iir_rd_i) |=> (iir_o[7:6] == 2'b00 && !iir_o[3]));

  // R5
  rls_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rls_i && ier_o[2] && !iir_rd_i) |=> (iir_o[3:0] == 4'b0110));

  // R8
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_rd_i |=> $stable(iir_o));

  // R4
  pend_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_i && ier_o[3]) |=> intr_o);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (.*);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fifo_mode_i = 1'b0;
  logic rls_i = 1'b0, rda_i = 1'b0, cto_i = 1'b0, thre_i = 1'b0, msi_i = 1'b0;
  logic iir_rd_i = 1'b0, ier_wr_i = 1'b0;
  logic [7:0] ier_wdata_i = '0;
  logic [7:0] ier_o, iir_o;
  logic intr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_mode_i(fifo_mode_i),
    .rls_i(rls_i), .rda_i(rda_i), .cto_i(cto_i), .thre_i(thre_i), .msi_i(msi_i),
    .iir_rd_i(iir_rd_i), .ier_wr_i(ier_wr_i), .ier_wdata_i(ier_wdata_i),
    .ier_o(ier_o), .iir_o(iir_o), .intr_o(intr_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", r, act, exp);
    end
  endtask

  task automatic set_src(logic l, logic d, logic t, logic e, logic m);
    rls_i = l; rda_i = d; cto_i = t; thre_i = e; msi_i = m;
  endtask

  task automatic wr_ier(logic [7:0] v);
    ier_wr_i = 1'b1; ier_wdata_i = v;
    step();
    ier_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ier", ier_o, 8'h00);
    chk("R1 iir", iir_o, 8'h01);
    chk("R1 intr", {7'd0, intr_o}, 8'h00);
  endtask

  task automatic t_ier();
    wr_ier(8'hFF); chk("R2 ff", ier_o, 8'h0F);
    wr_ier(8'h05); chk("R2 05", ier_o, 8'h05);
    wr_ier(8'h00); chk("R2 00", ier_o, 8'h00);
  endtask

  task automatic t_mask();
    fifo_mode_i = 1'b1;
    set_src(1, 1, 1, 1, 1);
    step(); step();
    chk("R3 iir", iir_o, 8'hC1);
    chk("R3 intr", {7'd0, intr_o}, 8'h00);
  endtask

  task automatic t_prio();
    fifo_mode_i = 1'b1;
    set_src(1, 1, 1, 1, 1);
    wr_ier(8'h0F); step();
    chk("R5 rls", iir_o, 8'hC6);
    chk("R4 intr on", {7'd0, intr_o}, 8'h01);
    rls_i = 0; step(); chk("R5 rda", iir_o, 8'hC4);
    rda_i = 0; step(); chk("R5 cto", iir_o, 8'hCC);
    cto_i = 0; step(); chk("R5 thre", iir_o, 8'hC2);
    thre_i = 0; step(); chk("R5 msi", iir_o, 8'hC0);
    chk("R4 msi intr", {7'd0, intr_o}, 8'h01);
    msi_i = 0; step(); chk("R4 none", iir_o, 8'hC1);
    chk("R4 intr off", {7'd0, intr_o}, 8'h00);
  endtask

  task automatic t_map();
    fifo_mode_i = 1'b1;
    set_src(1, 1, 1, 1, 1);
    wr_ier(8'h01); step(); chk("R10 b0", iir_o, 8'hC4);
    wr_ier(8'h02); step(); chk("R10 b1", iir_o, 8'hC2);
    wr_ier(8'h04); step(); chk("R10 b2", iir_o, 8'hC6);
    wr_ier(8'h08); step(); chk("R10 b3", iir_o, 8'hC0);
    set_src(0, 0, 1, 0, 0);
    wr_ier(8'h01); step(); chk("R10 b0 cto", iir_o, 8'hCC);
    set_src(0, 0, 0, 0, 0);
    step();
  endtask

  task automatic t_fifo();
    wr_ier(8'h0F);
    fifo_mode_i = 1'b0;
    set_src(0, 0, 1, 0, 0);
    step(); step();
    chk("R7 cto off", iir_o, 8'h01);
    chk("R7 intr", {7'd0, intr_o}, 8'h00);
    set_src(0, 1, 0, 0, 0); step();
    chk("R6 no fifo", iir_o, 8'h04);
    fifo_mode_i = 1'b1; set_src(0, 0, 1, 0, 0); step();
    chk("R6 fifo cto", iir_o, 8'hCC);
    set_src(0, 0, 0, 0, 0); step();
  endtask

  task automatic t_freeze();
    fifo_mode_i = 1'b1;
    wr_ier(8'h0F);
    set_src(0, 0, 0, 1, 0); step();
    chk("R8 before", iir_o, 8'hC2);
    iir_rd_i = 1'b1; rls_i = 1'b1;
    step(); chk("R8 held", iir_o, 8'hC2);
    step(); chk("R8 held2", iir_o, 8'hC2);
    set_src(0, 0, 0, 0, 0);
    step(); chk("R8 held3", iir_o, 8'hC2);
    chk("R9 intr live", {7'd0, intr_o}, 8'h00);
    rls_i = 1'b1; iir_rd_i = 1'b0;
    step(); chk("R8 release", iir_o, 8'hC6);
    chk("R9 intr back", {7'd0, intr_o}, 8'h01);
    set_src(0, 0, 0, 0, 0); step();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2 + 3);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_ier();
    t_mask();
    t_prio();
    t_map();
    t_fifo();
    t_freeze();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule